// File: doc/BRIEF.md
# I2C Serial Clock Bit-Timing Generator

This block produces the serial clock waveform for an I2C master, together with the timing strobes a byte-level controller needs to place data changes and data samples. From the system clock, a speed selection (standard, fast or high-speed) and a divider value, it works out how many system-clock cycles the clock line stays low and high within each bit. It then repeats that low-then-high pattern for as long as it is enabled.

In standard and fast mode the bit is split into two halves, each rounded up. Each half is then raised to the minimum low time or high time that the selected mode demands. With the default parameters at a 50 MHz system clock, the standard-mode high time is never shorter than 4 µs. In high-speed mode the high time is one third of the divider, rounded up and raised to its own floor. The low time is always exactly twice the high time, which gives a 1:2 high-to-low shape.

The controller uses three one-cycle strobes. A drive strobe falls in the middle of every low phase, and that is where data may change. A sample strobe falls in the middle of every high phase. A bit-end strobe marks the last cycle of each bit. The speed and divider are captured only when the generator starts from idle. To change speed, the controller drops the enable, updates the settings and enables the generator again.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and on every cycle while the generator is idle, `scl_o` is 1 (released), `busy_o` is 0, `phase_o` is 2'b00, and all three strobes are 0.
- R2: When `enable_i` is sampled high on a clock edge while idle, a bit begins on that edge. `scl_o` then stays 0 for L cycles (`phase_o` = 2'b01) and 1 for H cycles (`phase_o` = 2'b10). This low-then-high pattern repeats while `enable_i` stays high.
- R3: With `mode_i` = 2'b00 (standard), let D be `div_i`. Then H = max(ceil(D/2), STD_MIN_HIGH) and L = max(ceil(D/2), STD_MIN_LOW). The reserved code 2'b11 behaves as standard, and `active_mode_o` reports it as 2'b00.
- R4: With `mode_i` = 2'b01 (fast), H = max(ceil(D/2), FAST_MIN_HIGH) and L = max(ceil(D/2), FAST_MIN_LOW).
- R5: With `mode_i` = 2'b10 (high-speed), H = max(ceil(D/3), HS_MIN_HIGH) and L = 2·H.
- R6: `drive_tick_o` is 1 for exactly one cycle per low phase, at 0-based cycle index floor(L/2) of that phase.
- R7: `sample_tick_o` is 1 for exactly one cycle per high phase, at 0-based cycle index floor(H/2) of that phase.
- R8: `bit_done_o` is 1 for exactly one cycle per bit: the last cycle of the high phase (index H-1).
- R9: The speed and divider are captured when a bit sequence starts from idle. Changes to `mode_i` or `div_i` while busy do not alter L, H or `active_mode_o`.
- R10: When `enable_i` is sampled low, the generator is idle from the next cycle on, in the state R1 describes. A later start captures the settings present at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Run request; low forces idle |
| mode_i | input | 2 | Speed select: 00 standard, 01 fast, 10 high-speed, 11 treated as standard |
| div_i | input | DIV_W (12) | Bit-length divider in system-clock cycles |
| scl_o | output | 1 | Serial clock level, 1 = released |
| phase_o | output | 2 | 00 idle, 01 low phase, 10 high phase |
| busy_o | output | 1 | A bit sequence is running |
| drive_tick_o | output | 1 | Mid-low strobe for data changes |
| sample_tick_o | output | 1 | Mid-high strobe for data sampling |
| bit_done_o | output | 1 | Last cycle of the current bit |
| active_mode_o | output | 2 | Speed captured for the running sequence |

## Verification
The bench builds the block with its defaults. These are a 12-bit divider and minimum phase lengths of 200/235 cycles (standard), 30/65 (fast) and 3 (high-speed high), which match the real bus limits at a 50 MHz clock. With these values the bench reaches each kind of phase length. One divider value is clamped up by the standard minimums. Another shows the fast-mode low floor taking over from an even split. Odd dividers show the round-up in both the halving and the thirding, and a very small high-speed divider is lifted to its floor. All phases stay short enough that the whole run, including mid-run setting changes, an abrupt disable and a restart, needs only a few thousand cycles.

// File: rtl/scl_timing_pkg.sv
// Package: shared encodings for the serial clock bit-timing generator.
// Assumes: speed codes and phase codes are visible at the top-level ports,
// so their values must stay fixed.
package scl_timing_pkg;

    typedef enum logic [1:0] {
        MODE_STD  = 2'b00,
        MODE_FAST = 2'b01,
        MODE_HS   = 2'b10,
        MODE_RSV  = 2'b11
    } scl_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } scl_phase_e;

endpackage

// File: rtl/scl_phase_calc.sv
// Module: scl_phase_calc
// Turns a speed selection and a divider into low and high phase lengths in
// system-clock cycles. Divisions round up and every result is raised to the
// mode's minimum, so a minimum bus time is never cut short.
// Assumes: every minimum is at least 1 and fits in CNT_W-1 bits.
module scl_phase_calc
    import scl_timing_pkg::*;
#(
    parameter int DIV_W         = 12,
    parameter int CNT_W         = DIV_W + 1,
    parameter int STD_MIN_HIGH  = 200,
    parameter int STD_MIN_LOW   = 235,
    parameter int FAST_MIN_HIGH = 30,
    parameter int FAST_MIN_LOW  = 65,
    parameter int HS_MIN_HIGH   = 3
) (
    input  logic [1:0]       mode_raw,
    input  logic [DIV_W-1:0] div_val,
    output scl_mode_e        eff_mode,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len
);

    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);
    localparam logic [CNT_W-1:0] THREE    = CNT_W'(3);
    localparam logic [CNT_W-1:0] STD_HI_C = CNT_W'(STD_MIN_HIGH);
    localparam logic [CNT_W-1:0] STD_LO_C = CNT_W'(STD_MIN_LOW);
    localparam logic [CNT_W-1:0] FST_HI_C = CNT_W'(FAST_MIN_HIGH);
    localparam logic [CNT_W-1:0] FST_LO_C = CNT_W'(FAST_MIN_LOW);
    localparam logic [CNT_W-1:0] HS_HI_C  = CNT_W'(HS_MIN_HIGH);

    logic [CNT_W-1:0] div_ext;
    logic [CNT_W-1:0] half_up;
    logic [CNT_W-1:0] third_up;
    logic [CNT_W-1:0] hs_hi;

    // Larger of two lengths.
    function automatic logic [CNT_W-1:0] len_max(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    // Parameter sanity: minimums must be usable and leave room for doubling.
    initial begin
        assert (STD_MIN_HIGH >= 1 && STD_MIN_LOW >= 1 && FAST_MIN_HIGH >= 1 &&
                FAST_MIN_LOW >= 1 && HS_MIN_HIGH >= 1)
            else $error("scl_phase_calc: minimum phase lengths must be at least 1");
        assert (STD_MIN_LOW < (1 << (CNT_W - 1)) && HS_MIN_HIGH < (1 << (CNT_W - 2)))
            else $error("scl_phase_calc: minimum phase lengths too wide for CNT_W");
    end

    // Rounded-up fractions of the divider.
    always_comb begin
        div_ext  = {1'b0, div_val};
        half_up  = (div_ext + ONE) >> 1;
        third_up = (div_ext + TWO) / THREE;
        hs_hi    = len_max(third_up, HS_HI_C);
    end

    // Map the raw code to an effective mode; the reserved code runs as standard.
    always_comb begin
        case (mode_raw)
            2'b01:   eff_mode = MODE_FAST;
            2'b10:   eff_mode = MODE_HS;
            default: eff_mode = MODE_STD;
        endcase
    end

    // Phase lengths for the effective mode.
    always_comb begin
        case (eff_mode)
            MODE_FAST: begin
                hi_len = len_max(half_up, FST_HI_C);
                lo_len = len_max(half_up, FST_LO_C);
            end
            MODE_HS: begin
                hi_len = hs_hi;
                lo_len = hs_hi << 1;
            end
            default: begin
                hi_len = len_max(half_up, STD_HI_C);
                lo_len = len_max(half_up, STD_LO_C);
            end
        endcase
    end

endmodule

// File: rtl/scl_phase_seq.sv
// Module: scl_phase_seq
// Runs the idle / low / high phase sequence with a cycle counter. It captures
// the phase lengths and the mode on the edge that leaves idle, and keeps them
// until the generator goes idle again.
// Assumes: captured lengths are at least 1.
module scl_phase_seq
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  scl_mode_e        cfg_mode,
    input  logic [CNT_W-1:0] cfg_hi,
    input  logic [CNT_W-1:0] cfg_lo,
    output scl_phase_e       phase_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] hi_q,
    output logic [CNT_W-1:0] lo_q,
    output scl_mode_e        mode_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic lo_last;
    logic hi_last;

    // Last-cycle flags of each phase.
    always_comb begin
        lo_last = (cnt_q == lo_q - ONE);
        hi_last = (cnt_q == hi_q - ONE);
    end

    // Phase sequencing, counting and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            hi_q    <= ONE;
            lo_q    <= ONE;
            mode_q  <= MODE_STD;
        end else if (!enable) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                    hi_q    <= cfg_hi;
                    lo_q    <= cfg_lo;
                    mode_q  <= cfg_mode;
                end
                PH_LOW: begin
                    if (lo_last) begin
                        phase_q <= PH_HIGH;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                PH_HIGH: begin
                    if (hi_last) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // R9: captured settings do not move while a sequence is running.
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> (phase_q == PH_IDLE) ||
            ($stable(mode_q) && $stable(hi_q) && $stable(lo_q)))
        else $error("captured configuration changed while running");

    // R2: the counter never passes the end of the current phase.
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_LOW) |-> (cnt_q < lo_q)) and
        ((phase_q == PH_HIGH) |-> (cnt_q < hi_q)))
        else $error("phase counter out of range");

    // R10: a low enable always leads to idle on the next cycle.
    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase_q == PH_IDLE))
        else $error("generator not idle after disable");

    // R2: a low phase is always followed by a high phase while enabled.
    assert_low_then_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH) |-> ($past(phase_q) != PH_IDLE))
        else $error("high phase entered straight from idle");

endmodule

// File: rtl/scl_tick_gen.sv
// Module: scl_tick_gen
// Decodes the clock level and the three strobes from the phase, the counter
// and the captured lengths. Everything here is combinational from registers,
// so the outputs change only just after a clock edge.
// Assumes: lengths are at least 1; clk and rst_n serve only the assertions.
module scl_tick_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scl_phase_e       phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             scl,
    output logic             drive_tick,
    output logic             sample_tick,
    output logic             bit_done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Line level: only the low phase pulls the clock down.
    always_comb scl = (phase != PH_LOW);

    // Mid-phase strobes and end-of-bit strobe.
    always_comb begin
        drive_tick  = (phase == PH_LOW)  && (cnt == (lo_len >> 1));
        sample_tick = (phase == PH_HIGH) && (cnt == (hi_len >> 1));
        bit_done    = (phase == PH_HIGH) && (cnt == hi_len - ONE);
    end

    // R6: data changes are strobed only while the clock is low.
    assert_drive_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drive_tick |-> !scl)
        else $error("drive strobe outside low phase");

    // R7: sampling is strobed only while the clock is high.
    assert_sample_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> scl)
        else $error("sample strobe outside high phase");

    // R1: idle means a released clock and silent strobes.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (scl && !drive_tick && !sample_tick && !bit_done))
        else $error("activity while idle");

    // R8: the end-of-bit strobe is a single-cycle pulse.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done)
        else $error("end-of-bit strobe longer than one cycle");

endmodule

// File: rtl/scl_timing_gen.sv
// Module: scl_timing_gen (top)
// Serial clock bit-timing generator for an I2C master. It joins the length
// calculator, the phase sequencer and the strobe decoder.
// Assumes: a 50 MHz system clock for the default minimum lengths; the
// controller changes speed only by dropping enable first.
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int DIV_W         = 12,
    parameter int STD_MIN_HIGH  = 200,
    parameter int STD_MIN_LOW   = 235,
    parameter int FAST_MIN_HIGH = 30,
    parameter int FAST_MIN_LOW  = 65,
    parameter int HS_MIN_HIGH   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [1:0]       mode_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             scl_o,
    output logic [1:0]       phase_o,
    output logic             busy_o,
    output logic             drive_tick_o,
    output logic             sample_tick_o,
    output logic             bit_done_o,
    output logic [1:0]       active_mode_o
);

    localparam int CNT_W = DIV_W + 1;

    scl_mode_e        calc_mode;
    logic [CNT_W-1:0] calc_hi;
    logic [CNT_W-1:0] calc_lo;
    scl_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] lo_q;
    scl_mode_e        mode_q;

    scl_phase_calc #(
        .DIV_W        (DIV_W),
        .CNT_W        (CNT_W),
        .STD_MIN_HIGH (STD_MIN_HIGH),
        .STD_MIN_LOW  (STD_MIN_LOW),
        .FAST_MIN_HIGH(FAST_MIN_HIGH),
        .FAST_MIN_LOW (FAST_MIN_LOW),
        .HS_MIN_HIGH  (HS_MIN_HIGH)
    ) u_calc (
        .mode_raw(mode_i),
        .div_val (div_i),
        .eff_mode(calc_mode),
        .hi_len  (calc_hi),
        .lo_len  (calc_lo)
    );

    scl_phase_seq #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable_i),
        .cfg_mode(calc_mode),
        .cfg_hi  (calc_hi),
        .cfg_lo  (calc_lo),
        .phase_q (phase_q),
        .cnt_q   (cnt_q),
        .hi_q    (hi_q),
        .lo_q    (lo_q),
        .mode_q  (mode_q)
    );

    scl_tick_gen #(
        .CNT_W(CNT_W)
    ) u_ticks (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase_q),
        .cnt        (cnt_q),
        .hi_len     (hi_q),
        .lo_len     (lo_q),
        .scl        (scl_o),
        .drive_tick (drive_tick_o),
        .sample_tick(sample_tick_o),
        .bit_done   (bit_done_o)
    );

    // Status outputs from the sequencer state.
    always_comb begin
        phase_o       = phase_q;
        busy_o        = (phase_q != PH_IDLE);
        active_mode_o = mode_q;
    end

    // R3: a running standard sequence honours both standard minimums.
    assert_std_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_q == MODE_STD) |->
            (hi_q >= CNT_W'(STD_MIN_HIGH) && lo_q >= CNT_W'(STD_MIN_LOW)))
        else $error("standard minimum phase length violated");

    // R4: a running fast sequence honours both fast minimums.
    assert_fast_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_q == MODE_FAST) |->
            (hi_q >= CNT_W'(FAST_MIN_HIGH) && lo_q >= CNT_W'(FAST_MIN_LOW)))
        else $error("fast minimum phase length violated");

    // R5: a running high-speed sequence has a 1:2 high-to-low shape.
    assert_hs_ratio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_q == MODE_HS) |->
            (lo_q == (hi_q << 1) && hi_q >= CNT_W'(HS_MIN_HIGH)))
        else $error("high-speed 1:2 ratio violated");

    // R8: after the end-of-bit strobe the line goes low or the block goes idle.
    assert_done_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done_o |=> (phase_q != PH_HIGH))
        else $error("high phase continued past end-of-bit strobe");

endmodule

// File: tb/sim_scl_timing_gen.sv
// Directed bench for scl_timing_gen: one task per scenario, each checking
// its own results. Inputs change on falling edges; outputs are sampled there.
module sim_scl_timing_gen;

    localparam int DIV_W = 12;
    localparam int GUARD = 5000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable_i = 1'b0;
    logic [1:0]       mode_i = 2'b00;
    logic [DIV_W-1:0] div_i = '0;
    logic             scl_o;
    logic [1:0]       phase_o;
    logic             busy_o;
    logic             drive_tick_o;
    logic             sample_tick_o;
    logic             bit_done_o;
    logic [1:0]       active_mode_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    scl_timing_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .mode_i       (mode_i),
        .div_i        (div_i),
        .scl_o        (scl_o),
        .phase_o      (phase_o),
        .busy_o       (busy_o),
        .drive_tick_o (drive_tick_o),
        .sample_tick_o(sample_tick_o),
        .bit_done_o   (bit_done_o),
        .active_mode_o(active_mode_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected lengths straight from R3, R4 and R5.
    function automatic void expect_len(input int mode, input int d, output int h, output int l);
        if (mode == 1) begin
            h = imax((d + 1) / 2, 30);
            l = imax((d + 1) / 2, 65);
        end else if (mode == 2) begin
            h = imax((d + 2) / 3, 3);
            l = 2 * h;
        end else begin
            h = imax((d + 1) / 2, 200);
            l = imax((d + 1) / 2, 235);
        end
    endfunction

    // Measures one bit; called on the falling edge of the bit's first low cycle
    // is reached by the first wait below, or directly when already there.
    task automatic measure(input bit wait_first, output int lo_n, output int hi_n,
                           output int drv_i, output int drv_n, output int smp_i,
                           output int smp_n, output int done_i, output int done_n);
        int g;
        lo_n = 0; hi_n = 0; drv_i = -1; drv_n = 0;
        smp_i = -1; smp_n = 0; done_i = -1; done_n = 0; g = 0;
        if (wait_first) @(negedge clk);
        while (scl_o == 1'b0 && g < GUARD) begin
            if (drive_tick_o) begin drv_i = lo_n; drv_n++; end
            if (sample_tick_o || bit_done_o) smp_n += 100;
            lo_n++; g++;
            @(negedge clk);
        end
        while (scl_o == 1'b1 && busy_o && g < GUARD) begin
            if (sample_tick_o) begin smp_i = hi_n; smp_n++; end
            if (bit_done_o) begin done_i = hi_n; done_n++; end
            if (drive_tick_o) drv_n += 100;
            hi_n++; g++;
            @(negedge clk);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // One full bit in a given mode; checks lengths, strobes and status.
    task automatic t_bit(input string req, input int mode, input int d, input int exp_mode);
        int eh, el, lo_n, hi_n, drv_i, drv_n, smp_i, smp_n, done_i, done_n;
        expect_len(mode, d, eh, el);
        go_idle();
        mode_i = 2'(mode);
        div_i = DIV_W'(d);
        enable_i = 1'b1;
        @(negedge clk);
        chk("R2", "phase at start", int'(phase_o), 1);
        chk(req, "active mode", int'(active_mode_o), exp_mode);
        measure(1'b0, lo_n, hi_n, drv_i, drv_n, smp_i, smp_n, done_i, done_n);
        chk(req, "low length", lo_n, el);
        chk(req, "high length", hi_n, eh);
        chk("R6", "drive strobe index", drv_i, el / 2);
        chk("R6", "drive strobe count", drv_n, 1);
        chk("R7", "sample strobe index", smp_i, eh / 2);
        chk("R7", "sample strobe count", smp_n, 1);
        chk("R8", "bit end index", done_i, eh - 1);
        chk("R8", "bit end count", done_n, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "scl after reset", int'(scl_o), 1);
        chk("R1", "busy after reset", int'(busy_o), 0);
        chk("R1", "phase after reset", int'(phase_o), 0);
        chk("R1", "strobes after reset",
            int'(drive_tick_o) + int'(sample_tick_o) + int'(bit_done_o), 0);
    endtask

    // R9: settings changed mid-run leave two later bits untouched.
    task automatic t_ignore_change();
        int lo_n, hi_n, drv_i, drv_n, smp_i, smp_n, done_i, done_n;
        go_idle();
        mode_i = 2'b01;
        div_i = DIV_W'(200);
        enable_i = 1'b1;
        @(negedge clk);
        mode_i = 2'b10;
        div_i = DIV_W'(14);
        measure(1'b0, lo_n, hi_n, drv_i, drv_n, smp_i, smp_n, done_i, done_n);
        chk("R9", "first bit low", lo_n, 100);
        chk("R9", "first bit high", hi_n, 100);
        measure(1'b0, lo_n, hi_n, drv_i, drv_n, smp_i, smp_n, done_i, done_n);
        chk("R9", "second bit low", lo_n, 100);
        chk("R9", "second bit high", hi_n, 100);
        chk("R9", "active mode held", int'(active_mode_o), 1);
    endtask

    // R10: abrupt disable goes idle next cycle, stays quiet, restart re-captures.
    task automatic t_disable();
        int quiet, lo_n, hi_n, drv_i, drv_n, smp_i, smp_n, done_i, done_n;
        go_idle();
        mode_i = 2'b00;
        div_i = DIV_W'(500);
        enable_i = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10", "low before disable", int'(scl_o), 0);
        enable_i = 1'b0;
        @(negedge clk);
        chk("R10", "scl after disable", int'(scl_o), 1);
        chk("R10", "busy after disable", int'(busy_o), 0);
        chk("R10", "phase after disable", int'(phase_o), 0);
        quiet = 0;
        mode_i = 2'b10;
        div_i = DIV_W'(14);
        for (int i = 0; i < 300; i++) begin
            if (!scl_o || drive_tick_o || sample_tick_o || bit_done_o || busy_o) quiet++;
            @(negedge clk);
        end
        chk("R1", "activity while disabled", quiet, 0);
        enable_i = 1'b1;
        measure(1'b1, lo_n, hi_n, drv_i, drv_n, smp_i, smp_n, done_i, done_n);
        chk("R10", "restart low uses new settings", lo_n, 10);
        chk("R10", "restart high uses new settings", hi_n, 5);
        chk("R10", "restart mode", int'(active_mode_o), 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_bit("R3", 0, 500, 0);   // even split 250/250
        t_bit("R3", 0, 101, 0);   // clamped to 200/235
        t_bit("R3", 0, 501, 0);   // rounded up 251/251
        t_bit("R3", 3, 600, 0);   // reserved code as standard
        t_bit("R4", 1, 125, 1);   // 63 high, 65 low floor
        t_bit("R4", 1, 200, 1);   // 100/100
        t_bit("R5", 2, 14, 2);    // 5/10
        t_bit("R5", 2, 4, 2);     // floor 3/6
        t_bit("R5", 2, 31, 2);    // round up 11/22
        t_ignore_change();
        t_disable();
        go_idle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule